// File: doc/BRIEF.md
# Framed PCM Serial Port

This block is the master side of a synchronous serial link that trades one 16-bit voice sample in each direction with an external DSP once per 8 kHz frame. It derives the serial clock and a frame enable from the system clock and an asynchronous frame-sync input. It shifts the send word out MSB first and assembles the receive word from the serial input. The codec datapath hands the send word over in parallel, and gets the receive word back in parallel with a one-cycle valid strobe.

An active-low request input allows or refuses each frame; its level is taken when the frame edge is seen. A mode pin selects between two polarity schemes. A hold input parks the link at its idle levels and drops any frame in flight.

Top module: `pcm_port`

## Requirements
- R1: While and right after reset, rx_valid_o is low and sclk_o and en_o sit at the idle level of the selected mode (low with mode_i=1, high with mode_i=0).
- R2: fsync_i and req_ni each pass through a two-flop synchronizer. When req_ni is low and a rising edge of fsync_i is seen, the enable becomes active on the third rising clk_i edge after fsync_i rises, and the serial clock makes its first active-going transition in the same cycle.
- R3: When req_ni is high at the frame edge, the frame is refused: no enable window opens, no clock transitions happen, so_o stays 0 and no rx_valid_o pulse follows.
- R4: A started frame runs 2*SLOTS half-periods of HALF_DIV system cycles each, so SLOTS serial clock periods in all. The enable covers the first WORD_W periods, which is 2*WORD_W*HALF_DIV system cycles.
- R5: tx_data_i is captured at frame start and later changes to it have no effect on that frame. The word leaves on so_o MSB first (bit WORD_W-1 in the first period). A new bit appears with each active-going clock transition inside the window, and so_o is 0 outside the window.
- R6: si_i is sampled on the inactive-going clock transition of each period inside the window, MSB first. Values on si_i at any other time do not reach rx_data_o.
- R7: The assembled word appears on rx_data_o with rx_valid_o high for exactly one cycle, the cycle in which the enable returns to idle.
- R8: With mode_i=1, the active levels of sclk_o and en_o are high and the idle levels are low. With mode_i=0, both outputs are inverted, so they idle high and the enable is active low.
- R9: While hold_i is high, sclk_o and en_o are at the mode's idle levels from the next cycle on. A frame in progress is dropped without an rx_valid_o pulse, and a frame edge that meets hold_i is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | 8 kHz frame sync, asynchronous |
| req_ni | input | 1 | Frame request, low allows transfer, asynchronous |
| mode_i | input | 1 | 1 = non-inverted timing, 0 = inverted clock and enable |
| hold_i | input | 1 | Forces idle levels and stops the transfer |
| tx_data_i | input | WORD_W | Send sample, two's complement |
| si_i | input | 1 | Serial data from the DSP |
| sclk_o | output | 1 | Generated serial clock |
| en_o | output | 1 | Frame enable |
| so_o | output | 1 | Serial data to the DSP |
| rx_data_o | output | WORD_W | Received sample, two's complement |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
Two functions can land in the same cycle: the synchronized frame edge that would start a transfer, and the hold input that forces idle. The bench raises hold_i exactly two falling clock edges after fsync_i, so hold is sampled high at the edge where the start would happen. It judges the result by counting no enable window and no valid strobe for that frame. A second case raises hold mid-window and expects the window to close early with no receive word and the clock parked at the idle level of the current mode.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    PCM_MODE_INV = 1'b0,
    PCM_MODE_STD = 1'b1
  } pcm_mode_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcm_bitclk.sv
module pcm_bitclk #(
  parameter int WORD_W   = 16,
  parameter int SLOTS    = 32,
  parameter int HALF_DIV = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic active_o,
  output logic sclk_o,
  output logic en_o,
  output logic adv_o,
  output logic cap_o,
  output logic end_o
);
  localparam int HALVES = 2 * SLOTS;
  localparam int WIN    = 2 * WORD_W;
  localparam int HW     = $clog2(HALVES);
  localparam int DW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] hc_q;
  logic [HW-1:0] hi_q;
  logic active_q, sclk_q, en_q;
  logic tick, last, win_end;

  assign tick    = active_q && (hc_q == DW'(HALF_DIV - 1));
  assign last    = tick && (hi_q == HW'(HALVES - 1));
  assign win_end = tick && (int'(hi_q) == WIN - 1);

  // odd half -> next even half inside window: next data bit
  assign adv_o = !hold_i && tick && hi_q[0] && (int'(hi_q) < WIN - 1);
  // even half -> odd half inside window: sample input
  assign cap_o = !hold_i && tick && !hi_q[0] && (int'(hi_q) < WIN);
  assign end_o = !hold_i && win_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      en_q     <= 1'b0;
      hc_q     <= '0;
      hi_q     <= '0;
    end else if (hold_i) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      en_q     <= 1'b0;
      hc_q     <= '0;
      hi_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b1;
      en_q     <= 1'b1;
      hc_q     <= '0;
      hi_q     <= '0;
    end else if (active_q) begin
      if (tick) begin
        hc_q <= '0;
        if (last) begin
          active_q <= 1'b0;
          sclk_q   <= 1'b0;
          hi_q     <= '0;
        end else begin
          hi_q   <= hi_q + HW'(1);
          sclk_q <= ~sclk_q;
        end
        if (win_end) en_q <= 1'b0;
      end else begin
        hc_q <= hc_q + DW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign en_o     = en_q;

  a_r4_en_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> active_q);
  a_r4_half_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(hc_q) < HALF_DIV);
  a_r9_hold_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!en_q && !sclk_q && !active_q));
  a_r2_start_opens_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active_q && !hold_i) |=> (en_q && sclk_q));
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              adv_i,
  input  logic              cap_i,
  input  logic              end_i,
  input  logic              en_i,
  input  logic              si_i,
  output logic              so_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              rx_valid_o
);
  logic [WORD_W-1:0] tx_sh, rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_o       <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      if (load_i)     tx_sh <= tx_i;
      else if (adv_i) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      if (cap_i) rx_sh <= {rx_sh[WORD_W-2:0], si_i};
      rx_valid_o <= end_i;
      if (end_i) rx_o <= rx_sh;
    end
  end

  assign so_o = en_i & tx_sh[WORD_W-1];
endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SLOTS    = 32,
  parameter int HALF_DIV = 98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              req_ni,
  input  logic              mode_i,
  input  logic              hold_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              si_i,
  output logic              sclk_o,
  output logic              en_o,
  output logic              so_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  pcm_mode_e mode_sel;
  logic [1:0] sync_q;
  logic fs_s, req_s, fs_last_q, fs_rise;
  logic start, active, sclk_q, en_q, adv, cap, win_end;

  pcm_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({req_ni, fsync_i}),
    .q_o   (sync_q)
  );
  assign fs_s  = sync_q[0];
  assign req_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fs_last_q <= 1'b0;
    else         fs_last_q <= fs_s;

  assign fs_rise = fs_s && !fs_last_q;
  assign start   = fs_rise && !req_s && !hold_i;

  pcm_bitclk #(.WORD_W(WORD_W), .SLOTS(SLOTS), .HALF_DIV(HALF_DIV)) u_bitclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hold_i  (hold_i),
    .active_o(active),
    .sclk_o  (sclk_q),
    .en_o    (en_q),
    .adv_o   (adv),
    .cap_o   (cap),
    .end_o   (win_end)
  );

  pcm_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start && !active),
    .tx_i      (tx_data_i),
    .adv_i     (adv),
    .cap_i     (cap),
    .end_i     (win_end),
    .en_i      (en_q),
    .si_i      (si_i),
    .so_o      (so_o),
    .rx_o      (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  assign mode_sel = pcm_mode_e'(mode_i);
  assign sclk_o   = (mode_sel == PCM_MODE_STD) ? sclk_q : ~sclk_q;
  assign en_o     = (mode_sel == PCM_MODE_STD) ? en_q   : ~en_q;

  a_r7_valid_at_window_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $fell(en_q));
  a_r3_refused_frame_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_rise && req_s && !active) |=> !active);
  a_r5_so_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_o) |-> ($rose(sclk_q) || $fell(en_q)));
endmodule

// File: tb/pcm_port_bench.sv
module pcm_port_bench;
  localparam int W  = 16;
  localparam int SL = 32;
  localparam int HD = 3;
  localparam int FP = 230;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync = 1'b0, req_n = 1'b1, mode = 1'b1, hold = 1'b0, si = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic sclk_o, en_o, so_o, rx_valid_o;
  logic [W-1:0] rx_data_o;

  pcm_port #(.WORD_W(W), .SLOTS(SL), .HALF_DIV(HD)) u_pcm_port (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .req_ni(req_n), .mode_i(mode),
    .hold_i(hold), .tx_data_i(tx_data), .si_i(si), .sclk_o(sclk_o), .en_o(en_o),
    .so_o(so_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  logic [W-1:0] q_tx[$], q_rx[$];
  logic [W-1:0] dsp_word = '0, so_acc = '0, got;
  int win_cnt = 0, rise_cnt = 0, valid_cnt = 0, bad_so = 0, k = 0, en_len = 0;
  logic p_sc = 1'b0, p_en = 1'b0, sc, en;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // DSP-side model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      sc = mode ? sclk_o : ~sclk_o;
      en = mode ? en_o : ~en_o;
      if (en && !p_en) begin
        win_cnt++; k = 0; so_acc = '0; en_len = 0; rise_cnt = 0;
      end
      if (sc && !p_sc) begin
        rise_cnt++;
        if (en && k < W) begin si = dsp_word[W-1-k]; k++; end
        else si = 1'($urandom);
      end
      if (!sc && p_sc && en) so_acc = {so_acc[W-2:0], so_o};
      if (!en && so_o) bad_so++;
      if (en) en_len++;
      if (!en && p_en && !hold) begin
        if (q_tx.size() == 0) chk(0, "R5", "unexpected window", 32'(so_acc), 0);
        else begin
          got = q_tx.pop_front();
          chk(so_acc == got, "R5", "serial send word", 32'(so_acc), 32'(got));
        end
        chk(en_len == 2*W*HD, "R4", "enable length", 32'(en_len), 32'(2*W*HD));
      end
      if (rx_valid_o) begin
        valid_cnt++;
        chk(p_en && !en, "R7", "valid not at window close", {30'd0, p_en, en}, 32'd2);
        if (q_rx.size() == 0) chk(0, "R6", "unexpected rx word", 32'(rx_data_o), 0);
        else begin
          got = q_rx.pop_front();
          chk(rx_data_o == got, "R6", "parallel receive word", 32'(rx_data_o), 32'(got));
        end
      end
      p_sc = sc; p_en = en;
    end
  end

  task automatic idle_chk(input string rq);
    logic lvl;
    lvl = mode ? 1'b0 : 1'b1;
    chk(sclk_o == lvl && en_o == lvl, rq, "idle levels", {30'd0, sclk_o, en_o}, {30'd0, lvl, lvl});
  endtask

  // kind: 0 normal, 1 hold meets frame edge, 2 hold mid-window
  task automatic frame(input bit rq_n, input logic [W-1:0] tx, input logic [W-1:0] rx, input int kind);
    int w0, v0;
    bit exp_win;
    req_n = rq_n; tx_data = tx; dsp_word = rx;
    repeat (5) @(negedge clk);
    w0 = win_cnt; v0 = valid_cnt; bad_so = 0;
    exp_win = !rq_n && kind != 1;
    if (exp_win && kind == 0) begin q_tx.push_back(tx); q_rx.push_back(rx); end
    fsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (kind == 1) begin
      hold = 1'b1;
      repeat (4) @(negedge clk);
      idle_chk("R9");
      hold = 1'b0;
    end else begin
      idle_chk("R2");
      @(negedge clk);
      chk(en_o == (mode ? exp_win : !exp_win), rq_n ? "R3" : "R2", "enable after sync",
          32'(en_o), 32'(mode ? exp_win : !exp_win));
      tx_data = ~tx;
      if (kind == 2) begin
        repeat (40) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        idle_chk("R9");
        repeat (3) @(negedge clk);
        idle_chk("R9");
        hold = 1'b0;
      end
    end
    repeat (10) @(negedge clk);
    fsync = 1'b0;
    repeat (FP) @(negedge clk);
    chk(win_cnt - w0 == int'(exp_win), rq_n ? "R3" : "R2", "window count", 32'(win_cnt - w0), 32'(exp_win));
    chk(valid_cnt - v0 == int'(exp_win && kind == 0), kind != 0 ? "R9" : "R7", "valid count",
        32'(valid_cnt - v0), 32'(exp_win && kind == 0));
    chk(bad_so == 0, "R5", "so_o outside window", 32'(bad_so), 0);
    if (exp_win && kind == 0) chk(rise_cnt == SL, "R4", "serial periods", 32'(rise_cnt), 32'(SL));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o == 0 && en_o == 0 && rx_valid_o == 0, "R1", "reset outputs",
        {29'd0, sclk_o, en_o, rx_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1");
    frame(0, 16'h8001, 16'h7FFE, 0);
    frame(0, 16'hA5C3, 16'h1234, 0);
    frame(1, 16'hFFFF, 16'hFFFF, 0);
    frame(0, 16'h0000, 16'h8000, 0);
    frame(0, 16'h1357, 16'hBEEF, 2);
    frame(0, 16'h4242, 16'hC001, 0);
    frame(0, 16'h5555, 16'hAAAA, 1);
    mode = 1'b0;
    @(negedge clk);
    idle_chk("R8");
    frame(0, 16'h7FFF, 16'h0001, 0);
    frame(1, 16'h0F0F, 16'hF0F0, 0);
    frame(0, 16'hDEAD, 16'h2468, 2);
    frame(0, 16'hCAFE, 16'hF00D, 0);
    idle_chk("R8");
    chk(q_tx.size() == 0 && q_rx.size() == 0, "R6", "words left in scoreboard",
        32'(q_tx.size() + q_rx.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule